// File: doc/BRIEF.md
# Configurable SPI Master Shifter

An 8-bit SPI master shifter. A write to the data buffer while the block is idle starts a byte transfer at once. The block drives the serial clock, shifts the byte out most significant bit first on the serial data output, and shifts the serial data input in at the same time. At the end of the byte the received value is copied into the read buffer and a sticky interrupt flag is raised.

Software chooses the bit rate from four sources: the system clock divided by 4, 16 or 64, or an external timer tick divided by two. Three control bits set the shape of the clock:
- the idle level of SCK;
- whether output data is valid before the first clock edge or changes on it;
- whether the input is sampled in the middle of each data bit or at its end.

A receive-only control forces the serial output low and releases its output enable. The shifter keeps receiving at the programmed rate, so the block can watch line activity.

Top module: `spi_master_shifter`

## Requirements
- R1: A `wr_i` pulse while `busy_o` is low is accepted at that clock edge, and `busy_o` is high from the next cycle. The transfer lasts exactly 16 half-bit periods, and `busy_o` falls at the edge that ends the last half-period.
- R2: During bit k of the transfer (k = 0..7), `sdo_o` carries bit 7-k of the written byte, so the byte goes out most significant bit first.
- R3: While no transfer is running, `sck_o` equals `cfg_pol_i` (0 gives an idle-low clock, 1 gives an idle-high clock).
- R4: Each bit is split into a first half and a second half. With `cfg_cke_i`=1, `sck_o` is at its idle level in the first half and inverted in the second half, so data is valid before the first edge. With `cfg_cke_i`=0, `sck_o` is inverted in the first half and idle in the second half, so the first edge comes together with the first data bit.
- R5: With `cfg_smp_i`=0, `sdi_i` is captured at the edge that ends the first half of each bit. With `cfg_smp_i`=1, it is captured at the edge that ends the second half. The first captured bit ends up as bit 7 of the received byte.
- R6: `cfg_rate_i` sets one half-bit period. Code 0 gives 2 clocks, code 1 gives 8 clocks and code 2 gives 32 clocks, so the SCK period is 4, 16 or 64 clocks. Code 3 gives one `tmr_tick_i` pulse per half-period.
- R7: At the edge that ends the byte, `rdata_o` takes the received byte, and `irq_o` and `buf_full_o` are set.
- R8: While `cfg_rx_only_i`=1, `sdo_oe_o` and `sdo_o` are low. Reception, the buffer load and the flag behaviour are unchanged.
- R9: `irq_o` stays set until a `flag_clr_i` pulse. A buffer read does not clear it.
- R10: A `wr_i` pulse while `busy_o` is high is ignored: the transmitted bits and the received byte are unchanged. The pulse sets `wcol_o`, which stays set until a `flag_clr_i` pulse.
- R11: A `rd_ack_i` pulse clears `buf_full_o`. If a byte is loaded in the same cycle, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Data buffer write strobe |
| wdata_i | input | 8 | Byte to transmit |
| rd_ack_i | input | 1 | Buffer read strobe, clears buffer-full |
| rdata_o | output | 8 | Last received byte |
| cfg_pol_i | input | 1 | Idle level of SCK |
| cfg_cke_i | input | 1 | 1: data valid before first edge; 0: data changes on first edge |
| cfg_smp_i | input | 1 | 0: sample mid-bit; 1: sample at end of bit |
| cfg_rate_i | input | 2 | Rate select: 0 /4, 1 /16, 2 /64, 3 timer tick/2 |
| cfg_rx_only_i | input | 1 | Disable serial output, receive only |
| tmr_tick_i | input | 1 | External timer tick |
| flag_clr_i | input | 1 | Clears interrupt and write-collision flags |
| sdi_i | input | 1 | Serial data in |
| sck_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for serial data out |
| busy_o | output | 1 | Transfer in progress |
| irq_o | output | 1 | Byte-complete interrupt flag |
| buf_full_o | output | 1 | Received byte not yet read |
| wcol_o | output | 1 | Write collision flag |

## Verification
The hardest situation to reach is telling the two sample points apart. A slave that holds each bit steady for the whole bit time gives the same byte for both sample settings. The bench therefore drives `sdi_i` with one pattern during the first half of every bit and a different pattern during the second half. The expected byte depends on `cfg_smp_i`, and the bench derives the half-period boundaries from the clock count since the write. The timer-tick rate is aligned the same way, because the bench drives the tick itself on a fixed period. A write collision is forced by pulsing `wr_i` in the middle of a byte.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;
  typedef enum logic [1:0] {
    RATE_DIV_FAST = 2'd0,
    RATE_DIV_MID  = 2'd1,
    RATE_DIV_SLOW = 2'd2,
    RATE_TIMER    = 2'd3
  } rate_e;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_shift_pkg::*;
#(
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] rate_i,
  input  logic       tmr_tick_i,
  output logic       half_tick_o
);
  localparam int HALF_FAST = DIV_FAST / 2;
  localparam int HALF_MID  = DIV_MID / 2;
  localparam int HALF_SLOW = DIV_SLOW / 2;
  localparam int CNT_W     = (HALF_SLOW > 1) ? $clog2(HALF_SLOW) : 1;

  logic [CNT_W-1:0] cnt_q, lim_m1;
  logic             timer_mode;

  assign timer_mode = (rate_e'(rate_i) == RATE_TIMER);

  always_comb begin
    unique case (rate_e'(rate_i))
      RATE_DIV_FAST: lim_m1 = CNT_W'(HALF_FAST - 1);
      RATE_DIV_MID:  lim_m1 = CNT_W'(HALF_MID - 1);
      default:       lim_m1 = CNT_W'(HALF_SLOW - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!run_i || timer_mode)    cnt_q <= '0;
    else if (cnt_q == lim_m1)         cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  assign half_tick_o = run_i && (timer_mode ? tmr_tick_i : (cnt_q == lim_m1));

  // R6: a divided-clock half period is never shorter than two clocks
  p_tick_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_tick_o && !timer_mode && HALF_FAST > 1) |=> !half_tick_o);
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              half_tick_i,
  input  logic              pol_i,
  input  logic              cke_i,
  input  logic              smp_i,
  input  logic              sdi_i,
  output logic              busy_o,
  output logic              sck_o,
  output logic              msb_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic              busy_q, ph_q, mid_q, in_bit;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sr_q;

  // ph_q: 0 = first half of bit, 1 = second half
  assign in_bit = smp_i ? sdi_i : mid_q;
  assign rx_o   = {sr_q[DATA_W-2:0], in_bit};
  assign done_o = busy_q && half_tick_i && ph_q && (bit_q == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      mid_q  <= 1'b0;
      bit_q  <= '0;
      sr_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        ph_q   <= 1'b0;
        bit_q  <= '0;
        sr_q   <= wdata_i;
      end
    end else if (half_tick_i) begin
      ph_q <= ~ph_q;
      if (!ph_q) begin
        mid_q <= sdi_i;
      end else begin
        sr_q  <= rx_o;
        bit_q <= bit_q + 1'b1;
        if (bit_q == LAST_BIT) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign msb_o  = sr_q[DATA_W-1];
  assign sck_o  = busy_q ? (pol_i ^ ph_q ^ ~cke_i) : pol_i;

  // R1: a transfer never runs past its last bit
  p_bit_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/spi_status.sv
module spi_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] rx_i,
  input  logic              rd_ack_i,
  input  logic              collide_i,
  input  logic              flag_clr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              buf_full_o,
  output logic              wcol_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o    <= '0;
      irq_o      <= 1'b0;
      buf_full_o <= 1'b0;
      wcol_o     <= 1'b0;
    end else begin
      if (load_i) rdata_o <= rx_i;
      // set has priority over clear
      if (load_i)          irq_o <= 1'b1;
      else if (flag_clr_i) irq_o <= 1'b0;
      if (load_i)          buf_full_o <= 1'b1;
      else if (rd_ack_i)   buf_full_o <= 1'b0;
      if (collide_i)       wcol_o <= 1'b1;
      else if (flag_clr_i) wcol_o <= 1'b0;
    end
  end

  p_irq_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !flag_clr_i) |=> irq_o);
  p_full_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> buf_full_o);
endmodule

// File: rtl/spi_master_shifter.sv
module spi_master_shifter
  import spi_shift_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_ack_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              cfg_pol_i,
  input  logic              cfg_cke_i,
  input  logic              cfg_smp_i,
  input  logic [1:0]        cfg_rate_i,
  input  logic              cfg_rx_only_i,
  input  logic              tmr_tick_i,
  input  logic              flag_clr_i,
  input  logic              sdi_i,
  output logic              sck_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic              buf_full_o,
  output logic              wcol_o
);
  logic              half_tick, done, msb, start, collide;
  logic [DATA_W-1:0] rx_byte;

  assign start   = wr_i && !busy_o;
  assign collide = wr_i && busy_o;

  spi_rate_gen #(
    .DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)
  ) u_rate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (busy_o),
    .rate_i     (cfg_rate_i),
    .tmr_tick_i (tmr_tick_i),
    .half_tick_o(half_tick)
  );

  spi_bit_engine #(.DATA_W(DATA_W)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .wdata_i    (wdata_i),
    .half_tick_i(half_tick),
    .pol_i      (cfg_pol_i),
    .cke_i      (cfg_cke_i),
    .smp_i      (cfg_smp_i),
    .sdi_i      (sdi_i),
    .busy_o     (busy_o),
    .sck_o      (sck_o),
    .msb_o      (msb),
    .done_o     (done),
    .rx_o       (rx_byte)
  );

  spi_status #(.DATA_W(DATA_W)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (done),
    .rx_i       (rx_byte),
    .rd_ack_i   (rd_ack_i),
    .collide_i  (collide),
    .flag_clr_i (flag_clr_i),
    .rdata_o    (rdata_o),
    .irq_o      (irq_o),
    .buf_full_o (buf_full_o),
    .wcol_o     (wcol_o)
  );

  assign sdo_oe_o = !cfg_rx_only_i;
  assign sdo_o    = sdo_oe_o && msb;

  p_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !busy_o) |=> busy_o);
  p_sck_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sck_o == cfg_pol_i));
  p_done_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && half_tick && done) |=> (irq_o && buf_full_o && !busy_o));
  p_rx_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rx_only_i |-> (!sdo_o && !sdo_oe_o));
  p_wcol_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && busy_o) |=> wcol_o);
endmodule

// File: tb/tb_spi_master_shifter.sv
module tb_spi_master_shifter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd_ack = 1'b0, flag_clr = 1'b0, tick = 1'b0, sdi = 1'b0;
  logic [7:0] wdata = '0;
  logic       pol = 1'b0, cke = 1'b0, smp = 1'b0, rxo = 1'b0;
  logic [1:0] rate = 2'd0;
  logic [7:0] rdata;
  logic       sck, sdo, sdo_oe, busy, irq, bfull, wcol;
  int         checks = 0, errors = 0;
  bit         done_flag = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  spi_master_shifter dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wdata_i(wdata), .rd_ack_i(rd_ack),
    .rdata_o(rdata), .cfg_pol_i(pol), .cfg_cke_i(cke), .cfg_smp_i(smp),
    .cfg_rate_i(rate), .cfg_rx_only_i(rxo), .tmr_tick_i(tick), .flag_clr_i(flag_clr),
    .sdi_i(sdi), .sck_o(sck), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .busy_o(busy),
    .irq_o(irq), .buf_full_o(bfull), .wcol_o(wcol)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int half_len(input logic [1:0] r);
    case (r)
      2'd0: return 2;
      2'd1: return 8;
      2'd2: return 32;
      default: return 3;  // timer tick period used by the bench
    endcase
  endfunction

  // One byte transfer with a slave driving pattern a in first halves, b in second halves
  task automatic xfer(input logic [7:0] tx, input logic [7:0] a, input logic [7:0] b,
                      input bit inject_wr, input bit clear_after);
    int L = half_len(rate);
    int sck_bad = 0, sdo_bad = 0, len_bad = 0;
    logic [7:0] exp_rx = smp ? b : a;
    check(sck == pol && !busy, "R3 idle sck", sck, pol);
    wdata = tx; wr = 1'b1;
    @(negedge clk);  // after accepting edge: m = 0
    wr = 1'b0;
    for (int m = 0; m < 16 * L; m++) begin
      int h = m / L;
      int k = h / 2;
      logic exp_sck = (h % 2 == 0) ? (cke ? pol : ~pol) : (cke ? ~pol : pol);
      logic exp_sdo = rxo ? 1'b0 : tx[7-k];
      if (sck !== exp_sck) sck_bad++;
      if (sdo !== exp_sdo || sdo_oe !== !rxo) sdo_bad++;
      if (busy !== 1'b1) len_bad++;
      sdi  = (h % 2 == 0) ? a[7-k] : b[7-k];
      tick = (rate == 2'd3) && ((m + 1) % L == 0);
      wr    = inject_wr && (m == 5);
      wdata = (inject_wr && m == 5) ? ~tx : tx;
      @(negedge clk);
    end
    wr = 1'b0; tick = 1'b0;
    check(sck_bad == 0, "R4/R6 sck shape", sck_bad, 0);
    check(sdo_bad == 0, rxo ? "R8 sdo disabled" : "R2 sdo msb first", sdo_bad, 0);
    check(len_bad == 0 && !busy, "R1 transfer length", busy, 0);
    check(rdata == exp_rx, smp ? "R5 sample end" : "R5 sample mid", rdata, exp_rx);
    check(irq && bfull, "R7 flags on completion", {irq, bfull}, 2'b11);
    if (clear_after) begin
      flag_clr = 1'b1; rd_ack = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0; rd_ack = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sck == 1'b0 && !busy && !irq && !bfull && !wcol && rdata == 8'h00,
          "R3 reset state", {sck, busy, irq, bfull, wcol}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep every polarity/edge/sample/rate/receive-only combination
    for (int idx = 0; idx < 64; idx++) begin
      logic [7:0] tx = 8'hA5 ^ 8'(idx * 37);
      logic [7:0] a  = 8'(idx * 53 + 1);
      logic [7:0] b  = ~a ^ 8'(idx);
      pol  = idx[0]; cke = idx[1]; smp = idx[2];
      rate = 2'(idx >> 3); rxo = idx[5];
      @(negedge clk);
      xfer(tx, a, b, 1'b0, 1'b1);
    end

    // R9, R11: read clears buffer-full, not the interrupt
    pol = 1'b0; cke = 1'b1; smp = 1'b0; rate = 2'd0; rxo = 1'b0;
    @(negedge clk);
    xfer(8'h3C, 8'h96, 8'h69, 1'b0, 1'b0);
    rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0;
    check(!bfull, "R11 read clears buffer-full", bfull, 0);
    repeat (4) @(negedge clk);
    check(irq, "R9 irq sticky after read", irq, 1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check(!irq, "R9 clear strobe clears irq", irq, 0);

    // R10: write during transfer is ignored and flagged
    xfer(8'hC3, 8'h5A, 8'hF0, 1'b1, 1'b0);
    check(wcol, "R10 collision flag set", wcol, 1);
    check(rdata == 8'h5A, "R10 received byte unchanged", rdata, 8'h5A);
    repeat (3) @(negedge clk);
    check(wcol && !busy, "R10 collision flag held, no new transfer", {wcol, busy}, 2'b10);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check(!wcol && !irq, "R10 clear strobe clears collision", {wcol, irq}, 0);

    done_flag = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule